// File: doc/BRIEF.md
# Shadow Scan Chain for Processor Observation and Control

This block is a 64-bit serial scan chain that runs on the serial-link clock. It gives a host a view of a small processor and lets the host steer it. The chain has seven shadow segments:

- an 8-bit control segment,
- four 8-bit register shadows,
- an 8-bit program-counter shadow,
- a 16-bit instruction shadow.

On every rising edge of the serial clock the whole chain moves one place. A bit enters from the serial data input and the top bit of the control segment leaves on the serial data output. The host therefore reads the old contents out while it shifts new contents in.

A capture strobe takes a snapshot of the processor. While the strobe is high on a rising edge, each processor shadow loads its parallel capture input. The control segment reloads its own contents at that edge, so the control bits the host wrote survive every capture. The contents of every segment are always visible on output ports, so the processor can load state back from them. Two control bits are decoded into request flags:

- instruction-register bypass,
- decode squelch.

Top module: `scan_shadow_chain`

## Requirements
- R1: The serial path, from `mosi` toward `miso`, is instruction shadow (16 bits), program-counter shadow, R3, R2, R1, R0, then the control segment. `miso` is bit 7 of the control segment and changes only on a rising `spi_clk` edge.
- R2: On a rising edge with `capture` low, every segment shifts up by one bit (most significant bit toward the next segment). Its bit 0 takes the top bit of the segment before it, and the instruction shadow takes `mosi`.
- R3: On a rising edge with `capture` high, the instruction, program-counter and R0..R3 shadows load `cap_ir`, `cap_pc` and `cap_r0`..`cap_r3`, and nothing shifts. When two captures come back to back, the later values win.
- R4: A capture leaves the control segment unchanged.
- R5: `bypass_req` equals control bit 1 and `squelch_req` equals control bit 2.
- R6: Control bits 7:4 (a trigger field), bit 3 and bit 0 have no effect on `bypass_req` or `squelch_req`. They are still held and visible on `sh_ctrl`.
- R7: `rst_n` low clears every segment at once, without waiting for a clock edge. After `rst_n` rises, the first shift happens on the third rising `spi_clk` edge.
- R8: After 64 shifts with no capture, the chain holds exactly the 64 bits shifted in. The first bit shifted in ends up in bit 7 of `sh_ctrl`. The `sh_*` ports show each segment's contents at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| spi_clk | input | 1 | Serial clock; all chain state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mosi | input | 1 | Serial data into the instruction shadow |
| capture | input | 1 | Snapshot strobe; load instead of shift |
| cap_ir | input | 16 | Live instruction register value |
| cap_pc | input | 8 | Live program counter value |
| cap_r3 | input | 8 | Live R3 value |
| cap_r2 | input | 8 | Live R2 value |
| cap_r1 | input | 8 | Live R1 value |
| cap_r0 | input | 8 | Live R0 value |
| miso | output | 1 | Serial data out, top bit of control segment |
| sh_ctrl | output | 8 | Control segment contents |
| sh_r0 | output | 8 | R0 shadow contents |
| sh_r1 | output | 8 | R1 shadow contents |
| sh_r2 | output | 8 | R2 shadow contents |
| sh_r3 | output | 8 | R3 shadow contents |
| sh_pc | output | 8 | Program counter shadow contents |
| sh_ir | output | 16 | Instruction shadow contents |
| bypass_req | output | 1 | Instruction-register bypass request (control bit 1) |
| squelch_req | output | 1 | Decode squelch request (control bit 2) |

## Verification
The hardest point to reach is the edge where a capture meets a chain that is already full of host-written data. It must replace six segments at once, keep the seventh, and then the displaced bits must stream out on `miso` in the right order. The stimulus first fills the control segment by a full 64-bit shift, then fires single and back-to-back captures between further full shifts. A scoreboard predicts `miso` and every shadow port on each edge. Reset release is driven with `mosi` high so that an early or late first shift shows up directly in the instruction shadow.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Segment widths
  localparam int DATA_W  = 8;
  localparam int INSN_W  = 16;
  localparam int NUM_SEG = 7;
  localparam int CHAIN_W = (NUM_SEG - 1) * DATA_W + INSN_W - DATA_W + DATA_W;

  // Segment index along the chain, 0 is nearest the serial input
  localparam int SEG_IR   = 0;
  localparam int SEG_PC   = 1;
  localparam int SEG_R3   = 2;
  localparam int SEG_R2   = 3;
  localparam int SEG_R1   = 4;
  localparam int SEG_R0   = 5;
  localparam int SEG_CTRL = 6;

  // Control bit positions decoded by the processor
  localparam int BYPASS_BIT  = 1;
  localparam int SQUELCH_BIT = 2;

  function automatic int seg_width(input int idx);
    return (idx == SEG_IR) ? INSN_W : DATA_W;
  endfunction

  function automatic int seg_offset(input int idx);
    int sum;
    sum = 0;
    for (int k = 0; k < idx; k++) sum += seg_width(k);
    return sum;
  endfunction
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic meta_q;
  logic meta_d;
  logic out_d;

  always_comb begin
    meta_d = 1'b1;
    out_d  = meta_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q  <= 1'b0;
      rst_n_o <= 1'b0;
    end else begin
      meta_q  <= meta_d;
      rst_n_o <= out_d;
    end
  end
endmodule

// File: rtl/scan_seg.sv
module scan_seg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         load,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  // Load has priority over shift
  always_comb begin
    q_nxt = q;
    if (load)          q_nxt = par_in;
    else if (shift_en) q_nxt = {q[W-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R2
  msb_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift_en) |=> (q[W-1:1] == $past(q[W-2:0])));

  // R3
  par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(par_in)));
endmodule

// File: rtl/scan_shadow_chain.sv
module scan_shadow_chain
  import scan_pkg::*;
(
  input  logic              spi_clk,
  input  logic              rst_n,
  input  logic              mosi,
  input  logic              capture,
  input  logic [INSN_W-1:0] cap_ir,
  input  logic [DATA_W-1:0] cap_pc,
  input  logic [DATA_W-1:0] cap_r3,
  input  logic [DATA_W-1:0] cap_r2,
  input  logic [DATA_W-1:0] cap_r1,
  input  logic [DATA_W-1:0] cap_r0,
  output logic              miso,
  output logic [DATA_W-1:0] sh_ctrl,
  output logic [DATA_W-1:0] sh_r0,
  output logic [DATA_W-1:0] sh_r1,
  output logic [DATA_W-1:0] sh_r2,
  output logic [DATA_W-1:0] sh_r3,
  output logic [DATA_W-1:0] sh_pc,
  output logic [INSN_W-1:0] sh_ir,
  output logic              bypass_req,
  output logic              squelch_req
);
  localparam int CAP_W    = CHAIN_W - DATA_W;
  localparam int OFF_IR   = seg_offset(SEG_IR);
  localparam int OFF_PC   = seg_offset(SEG_PC);
  localparam int OFF_R3   = seg_offset(SEG_R3);
  localparam int OFF_R2   = seg_offset(SEG_R2);
  localparam int OFF_R1   = seg_offset(SEG_R1);
  localparam int OFF_R0   = seg_offset(SEG_R0);
  localparam int OFF_CTRL = seg_offset(SEG_CTRL);

  logic               rst_sync_n;
  logic [CHAIN_W-1:0] chain_q;
  logic [CAP_W-1:0]   cap_vec;

  scan_rst_sync u_rst_sync (
    .clk     (spi_clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign cap_vec = {cap_r0, cap_r1, cap_r2, cap_r3, cap_pc, cap_ir};

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    localparam int W   = seg_width(i);
    localparam int OFF = seg_offset(i);
    logic         sin;
    logic [W-1:0] pin;

    if (i == 0) begin : g_head
      assign sin = mosi;
    end else begin : g_link
      assign sin = chain_q[OFF-1];
    end

    if (i == SEG_CTRL) begin : g_self
      assign pin = chain_q[OFF +: W];
    end else begin : g_cap
      assign pin = cap_vec[OFF +: W];
    end

    scan_seg #(.W(W)) u_seg (
      .clk      (spi_clk),
      .rst_n    (rst_sync_n),
      .shift_en (1'b1),
      .load     (capture),
      .ser_in   (sin),
      .par_in   (pin),
      .q        (chain_q[OFF +: W])
    );
  end

  assign sh_ir   = chain_q[OFF_IR   +: INSN_W];
  assign sh_pc   = chain_q[OFF_PC   +: DATA_W];
  assign sh_r3   = chain_q[OFF_R3   +: DATA_W];
  assign sh_r2   = chain_q[OFF_R2   +: DATA_W];
  assign sh_r1   = chain_q[OFF_R1   +: DATA_W];
  assign sh_r0   = chain_q[OFF_R0   +: DATA_W];
  assign sh_ctrl = chain_q[OFF_CTRL +: DATA_W];
  assign miso    = chain_q[CHAIN_W-1];

  assign bypass_req  = sh_ctrl[BYPASS_BIT];
  assign squelch_req = sh_ctrl[SQUELCH_BIT];

  // R1
  link_r0_ctrl_chk: assert property (@(posedge spi_clk) disable iff (!rst_sync_n)
    !capture |=> (sh_ctrl[0] == $past(sh_r0[DATA_W-1])));

  // R1
  link_ir_pc_chk: assert property (@(posedge spi_clk) disable iff (!rst_sync_n)
    !capture |=> (sh_pc[0] == $past(sh_ir[INSN_W-1])));

  // R8
  mosi_entry_chk: assert property (@(posedge spi_clk) disable iff (!rst_sync_n)
    !capture |=> (sh_ir[0] == $past(mosi)));

  // R3
  cap_snapshot_chk: assert property (@(posedge spi_clk) disable iff (!rst_sync_n)
    capture |=> (sh_r2 == $past(cap_r2)) && (sh_ir == $past(cap_ir)));

  // R4
  ctrl_keep_chk: assert property (@(posedge spi_clk) disable iff (!rst_sync_n)
    capture |=> $stable(sh_ctrl));
endmodule

// File: tb/scan_shadow_chain_tb_top.sv
module scan_shadow_chain_tb_top;
  localparam time CLK_PER = 20ns;

  logic        spi_clk = 1'b0;
  logic        rst_n;
  logic        mosi;
  logic        capture;
  logic [15:0] cap_ir;
  logic [7:0]  cap_pc, cap_r3, cap_r2, cap_r1, cap_r0;
  logic        miso;
  logic [7:0]  sh_ctrl, sh_r0, sh_r1, sh_r2, sh_r3, sh_pc;
  logic [15:0] sh_ir;
  logic        bypass_req, squelch_req;

  always #(CLK_PER/2) spi_clk = ~spi_clk;

  scan_shadow_chain dut_i (
    .spi_clk(spi_clk), .rst_n(rst_n), .mosi(mosi), .capture(capture),
    .cap_ir(cap_ir), .cap_pc(cap_pc), .cap_r3(cap_r3), .cap_r2(cap_r2),
    .cap_r1(cap_r1), .cap_r0(cap_r0), .miso(miso), .sh_ctrl(sh_ctrl),
    .sh_r0(sh_r0), .sh_r1(sh_r1), .sh_r2(sh_r2), .sh_r3(sh_r3),
    .sh_pc(sh_pc), .sh_ir(sh_ir), .bypass_req(bypass_req),
    .squelch_req(squelch_req)
  );

  typedef struct packed {
    logic        cap;
    logic [63:0] chain;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] model;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;

  function automatic logic [63:0] ports_now();
    return {sh_ctrl, sh_r0, sh_r1, sh_r2, sh_r3, sh_pc, sh_ir};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Driver: called at a negedge; drives one edge and predicts its result
  task automatic step(input logic m, input logic c);
    exp_t it;
    mosi    = m;
    capture = c;
    if (c) model = {model[63:56], cap_r0, cap_r1, cap_r2, cap_r3, cap_pc, cap_ir};
    else   model = {model[62:0], m};
    it.cap   = c;
    it.chain = model;
    sb_q.push_back(it);
    @(negedge spi_clk);
  endtask

  task automatic shift_word(input logic [63:0] w);
    for (int k = 63; k >= 0; k--) step(w[k], 1'b0);
  endtask

  // Monitor: compares each predicted edge result mid high phase
  initial begin
    forever begin
      @(posedge spi_clk);
      #5ns;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        chk("R1 miso order", {63'd0, miso}, {63'd0, it.chain[63]});
        chk(it.cap ? "R3 capture contents" : "R2 shift contents", ports_now(), it.chain);
        chk("R5 request flags", {62'd0, squelch_req, bypass_req}, {62'd0, it.chain[58], it.chain[57]});
      end
    end
  end

  // Watchdog
  initial begin
    #(CLK_PER * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  localparam logic [63:0] P1 = {8'h02, 8'h5A, 8'hC3, 8'h96, 8'h3C, 8'hE1, 16'hBEEF};
  localparam logic [63:0] P2 = {8'hF4, 8'h01, 8'h80, 8'h7E, 8'hA5, 8'h0F, 16'h1234};
  localparam logic [63:0] P3 = {8'hF9, 8'hFF, 8'h00, 8'h55, 8'hAA, 8'h99, 16'hC001};
  localparam logic [63:0] P4 = {8'h06, 8'h10, 8'h20, 8'h40, 8'h80, 8'h08, 16'h8421};

  initial begin
    rst_n = 1'b0; mosi = 1'b0; capture = 1'b0;
    cap_ir = '0; cap_pc = '0; cap_r3 = '0; cap_r2 = '0; cap_r1 = '0; cap_r0 = '0;
    model = '0;
    repeat (3) @(negedge spi_clk);
    // R7 reset state
    chk("R7 reset clears chain", ports_now(), 64'd0);
    chk("R7 reset miso", {63'd0, miso}, 64'd0);

    // R7 release: two edges held, third edge shifts the 1
    rst_n = 1'b1; mosi = 1'b1;
    @(negedge spi_clk);
    @(negedge spi_clk);
    chk("R7 held during release sync", ports_now(), 64'd0);
    @(negedge spi_clk);
    chk("R7 first shift on third edge", {48'd0, sh_ir}, 64'd1);
    model = 64'd1;

    // R8 full load of the chain
    shift_word(P1);
    chk("R8 64 shifts replace chain", ports_now(), P1);
    chk("R5 bypass from bit 1", {62'd0, squelch_req, bypass_req}, 64'd1);

    // R3 / R4 capture with host control bits in place
    cap_r0 = 8'h11; cap_r1 = 8'h22; cap_r2 = 8'h33; cap_r3 = 8'h44;
    cap_pc = 8'h55; cap_ir = 16'h6677;
    step(1'b0, 1'b1);
    chk("R4 control kept on capture", {56'd0, sh_ctrl}, 64'h02);
    chk("R3 snapshot loaded", ports_now(), {8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 16'h6677});
    chk("R1 miso is control bit 7", {63'd0, miso}, 64'd0);

    // R5 squelch with trigger field set
    shift_word(P2);
    chk("R5 squelch from bit 2", {62'd0, squelch_req, bypass_req}, 64'd2);
    chk("R6 trigger field held", {56'd0, sh_ctrl}, 64'hF4);

    // R6 bits 7:4, 3 and 0 alone raise no request
    shift_word(P3);
    chk("R6 other control bits no effect", {62'd0, squelch_req, bypass_req}, 64'd0);
    chk("R8 chain after third word", ports_now(), P3);

    // R3 back-to-back captures, later wins
    cap_r0 = 8'hA1; cap_r1 = 8'hB2; cap_r2 = 8'hC3; cap_r3 = 8'hD4;
    cap_pc = 8'hE5; cap_ir = 16'hF00D;
    step(1'b1, 1'b1);
    cap_r0 = 8'h0A; cap_r1 = 8'h0B; cap_r2 = 8'h0C; cap_r3 = 8'h0D;
    cap_pc = 8'h0E; cap_ir = 16'hCAFE;
    step(1'b1, 1'b1);
    chk("R3 back-to-back capture", ports_now(), {8'hF9, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 16'hCAFE});

    // Partial shift then capture, then a full word with both flags
    for (int k = 0; k < 13; k++) step(k[0], 1'b0);
    step(1'b0, 1'b1);
    shift_word(P4);
    chk("R5 both flags", {62'd0, squelch_req, bypass_req}, 64'd3);
    chk("R8 chain after fourth word", ports_now(), P4);

    // R7 asynchronous clear mid-cycle
    rst_n = 1'b0;
    #1ns;
    chk("R7 asynchronous clear", ports_now(), 64'd0);
    chk("R7 miso cleared", {63'd0, miso}, 64'd0);
    @(negedge spi_clk);
    report();
  end
endmodule